// File: doc/BRIEF.md
# Serial GPIO Shift-Chain Controller

This block widens a host's general-purpose I/O by driving two external chains of 8-bit shift registers. One chain is built from serial-in/parallel-out latching registers and carries up to 64 output-only pins. The other chain is built from parallel-load/serial-out registers and brings in up to 64 input-only pins. The host writes eight byte-wide output registers and reads eight byte-wide input registers. Two runtime counts, one per direction, set how many 8-bit ports are active. The active port count for a direction is the pin count divided by eight, rounded up.

Once out of reset the block scans without stopping. Each scan first pulses the input load strobe. It then produces eight shift-clock periods for every port of the larger of the two active port counts, and ends by pulsing the output latch strobe. Serial output data changes only while the shift clock falls, so it is steady at every rising edge. Input data is collected in a shadow register and copied to the host-visible registers only when a scan completes. Output data is sampled from the host registers at the start of each scan.

Top module: `sgc_chain_top`

## Requirements
- R1: While reset is asserted, sclk, sdout, in_load and out_latch are low and every input register reads 0x00.
- R2: A write with wr_addr = a sets output register a. Register a holds pins 8a+7 down to 8a of the flat 64-bit output word, with pin 0 in bit 0 of register 0.
- R3: The active port count of a direction is ceil(min(count,64)/8). Every scan gives exactly 8*max(out ports, in ports) rising edges of sclk between consecutive out_latch pulses.
- R4: The highest active output port is shifted first, MSB first, and zero padding is sent ahead of it when the input chain is longer. After out_latch, the external chain bits 8*Nout-1..0 equal the flat output word bits 8*Nout-1..0.
- R5: The first serial bit received after in_load lands in bit 7 of input register Nin-1, and later bits fill downward to bit 0 of register 0. Bits received beyond 8*Nin are dropped, and registers at or above Nin read 0x00.
- R6: The input registers change only at the end of a complete scan. A read during shifting returns the result of the previous scan.
- R7: in_load is pulsed before the first shift clock of a scan, and out_latch after the last one. Neither strobe is high while sclk is high, and the two are never high together.
- R8: sdout changes only in the cycle in which sclk falls, never in the cycle in which sclk rises.
- R9: A count of zero suppresses that direction's strobe: in_load never pulses when the input count is zero, and out_latch never pulses when the output count is zero. With both counts zero, sclk stays low and the input registers read 0x00.
- R10: A count above 64 acts exactly as 64.
- R11: Both the high phase and the low phase of sclk last HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Output register write strobe |
| wr_addr | input | 3 | Output register index |
| wr_data | input | 8 | Output register write data |
| rd_addr | input | 3 | Input register index |
| rd_data | output | 8 | Input register read data (combinational) |
| out_count | input | 7 | Number of output pins in use |
| in_count | input | 7 | Number of input pins in use |
| sclk | output | 1 | Shift clock to both chains |
| sdout | output | 1 | Serial data to the output chain |
| out_latch | output | 1 | Output chain latch strobe, active high |
| sdin | input | 1 | Serial data from the input chain |
| in_load | output | 1 | Input chain parallel-load strobe, active high |

## Verification
A write or a count change is picked up at the idle cycle that opens the next scan. The output pins move on the out_latch pulse that ends that scan. The input registers move on the commit of the first scan that begins after the pattern is present, so a full result can be up to two scan lengths late, where one scan is 1 + 2*HALF_DIV + 16*HALF_DIV*max(ports) cycles. The bench therefore waits three worst-case scan lengths after each stimulus before comparing the external chain models and the input registers. It measures shift-edge counts and sclk phase widths between strobe edges, not at fixed cycle numbers. The stale-read check is sampled a few cycles after an in_load edge, while shifting is still under way.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_LATCH
  } scan_st_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sgc_rst_sync.sv
module sgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/sgc_count_decode.sv
module sgc_count_decode #(
  parameter int CNT_W = 7,
  parameter int PORTS = 8,
  localparam int PINS = PORTS * sgc_pkg::BYTE_W,
  localparam int BW   = $clog2(PINS + 1)
) (
  input  logic [CNT_W-1:0] pin_count,
  output logic [BW-1:0]    bit_count
);
  int sat;
  int nports;

  always_comb begin
    sat       = (int'(pin_count) > PINS) ? PINS : int'(pin_count);
    nports    = (sat + sgc_pkg::BYTE_W - 1) / sgc_pkg::BYTE_W;
    bit_count = BW'(nports * sgc_pkg::BYTE_W);
  end
endmodule

// File: rtl/sgc_host_regs.sv
module sgc_host_regs #(
  parameter int PORTS = 8,
  localparam int AW   = $clog2(PORTS),
  localparam int PINS = PORTS * sgc_pkg::BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  output logic [PINS-1:0] out_flat,
  input  logic [PINS-1:0] in_flat,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data
);
  genvar g;
  generate
    for (g = 0; g < PORTS; g++) begin : g_byte
      logic       byte_we;
      logic [7:0] byte_q;
      logic [7:0] byte_n;

      always_comb begin
        byte_we = wr_en && (wr_addr == AW'(g));
        byte_n  = byte_we ? wr_data : byte_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else        byte_q <= byte_n;
      end

      assign out_flat[g*8 +: 8] = byte_q;
    end
  endgenerate

  always_comb begin
    rd_data = in_flat[rd_addr*8 +: 8];
  end
endmodule

// File: rtl/sgc_phase_timer.sv
module sgc_phase_timer #(
  parameter int HALF_DIV = 2,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF_DIV - 1));
    cnt_n = (tick || !run) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sgc_scan_seq.sv
module sgc_scan_seq
  import sgc_pkg::*;
#(
  parameter int PORTS = 8,
  localparam int PINS = PORTS * BYTE_W,
  localparam int BW   = $clog2(PINS + 1),
  localparam int IW   = $clog2(PINS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW-1:0]   ob_in,
  input  logic [BW-1:0]   ib_in,
  input  logic [PINS-1:0] out_flat,
  input  logic            tick,
  output logic            run,
  output logic            sclk,
  output logic            sdout,
  output logic            in_load,
  output logic            out_latch,
  output logic            clr_shadow,
  output logic            sample,
  output logic [IW-1:0]   sample_idx,
  output logic            commit,
  output logic            wipe,
  output logic [BW-1:0]   ob,
  output logic [BW-1:0]   ib,
  output logic [BW-1:0]   tb
);
  localparam logic [BW-1:0] ONE = BW'(1);

  scan_st_t        st_q, st_n;
  logic [BW-1:0]   k_q, k_n;
  logic [BW-1:0]   ob_q, ob_n, ib_q, ib_n, tb_q, tb_n;
  logic [PINS-1:0] snap_q, snap_n;
  logic            sclk_q, sclk_n, sdo_q, sdo_n, ld_q, ld_n, lt_q, lt_n;
  logic [BW-1:0]   k_sel, idx, sidx, big;
  logic            bit_sel;

  always_comb begin
    st_n   = st_q;
    k_n    = k_q;
    ob_n   = ob_q;
    ib_n   = ib_q;
    tb_n   = tb_q;
    snap_n = snap_q;
    sclk_n = sclk_q;
    sdo_n  = sdo_q;
    ld_n   = ld_q;
    lt_n   = lt_q;
    clr_shadow = 1'b0;
    sample     = 1'b0;
    commit     = 1'b0;
    wipe       = 1'b0;

    big     = (ob_in > ib_in) ? ob_in : ib_in;
    k_sel   = (st_q == ST_HIGH) ? (k_q + ONE) : '0;
    idx     = tb_q - ONE - k_sel;
    bit_sel = (idx < ob_q) ? snap_q[idx[IW-1:0]] : 1'b0;
    sidx    = ib_q - ONE - k_q;
    sample_idx = sidx[IW-1:0];

    case (st_q)
      ST_IDLE: begin
        ob_n   = ob_in;
        ib_n   = ib_in;
        tb_n   = big;
        snap_n = out_flat;
        if (big != '0) begin
          st_n       = ST_LOAD;
          ld_n       = (ib_in != '0);
          clr_shadow = 1'b1;
        end else begin
          wipe = 1'b1;
        end
      end
      ST_LOAD: begin
        if (tick) begin
          st_n   = ST_LOW;
          ld_n   = 1'b0;
          k_n    = '0;
          sclk_n = 1'b0;
          sdo_n  = bit_sel;
        end
      end
      ST_LOW: begin
        if (tick) begin
          st_n   = ST_HIGH;
          sclk_n = 1'b1;
          sample = (k_q < ib_q);
        end
      end
      ST_HIGH: begin
        if (tick) begin
          sclk_n = 1'b0;
          if (k_q == tb_q - ONE) begin
            st_n   = ST_LATCH;
            sdo_n  = 1'b0;
            lt_n   = (ob_q != '0);
            commit = 1'b1;
          end else begin
            st_n  = ST_LOW;
            k_n   = k_q + ONE;
            sdo_n = bit_sel;
          end
        end
      end
      ST_LATCH: begin
        if (tick) begin
          st_n = ST_IDLE;
          lt_n = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      ob_q   <= '0;
      ib_q   <= '0;
      tb_q   <= '0;
      snap_q <= '0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      ld_q   <= 1'b0;
      lt_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      k_q    <= k_n;
      ob_q   <= ob_n;
      ib_q   <= ib_n;
      tb_q   <= tb_n;
      snap_q <= snap_n;
      sclk_q <= sclk_n;
      sdo_q  <= sdo_n;
      ld_q   <= ld_n;
      lt_q   <= lt_n;
    end
  end

  assign run       = (st_q != ST_IDLE);
  assign sclk      = sclk_q;
  assign sdout     = sdo_q;
  assign in_load   = ld_q;
  assign out_latch = lt_q;
  assign ob        = ob_q;
  assign ib        = ib_q;
  assign tb        = tb_q;
endmodule

// File: rtl/sgc_in_capture.sv
module sgc_in_capture #(
  parameter int PORTS = 8,
  localparam int PINS = PORTS * sgc_pkg::BYTE_W,
  localparam int IW   = $clog2(PINS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sdin,
  input  logic            clr_shadow,
  input  logic            sample,
  input  logic [IW-1:0]   sample_idx,
  input  logic            commit,
  input  logic            wipe,
  output logic [PINS-1:0] in_flat
);
  logic [PINS-1:0] shadow_q, shadow_n;
  logic [PINS-1:0] vis_q, vis_n;

  always_comb begin
    shadow_n = shadow_q;
    vis_n    = vis_q;
    if (clr_shadow) shadow_n = '0;
    else if (sample) shadow_n[sample_idx] = sdin;
    if (commit)    vis_n = shadow_q;
    else if (wipe) vis_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      vis_q    <= '0;
    end else begin
      shadow_q <= shadow_n;
      vis_q    <= vis_n;
    end
  end

  assign in_flat = vis_q;
endmodule

// File: rtl/sgc_chain_top.sv
module sgc_chain_top #(
  parameter int PORTS    = 8,
  parameter int CNT_W    = 7,
  parameter int HALF_DIV = 2,
  localparam int PINS = PORTS * sgc_pkg::BYTE_W,
  localparam int AW   = $clog2(PORTS),
  localparam int BW   = $clog2(PINS + 1),
  localparam int IW   = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] out_count,
  input  logic [CNT_W-1:0] in_count,
  output logic             sclk,
  output logic             sdout,
  output logic             out_latch,
  input  logic             sdin,
  output logic             in_load
);
  logic                  rst_i_n;
  logic [PINS-1:0]       out_flat;
  logic [PINS-1:0]       in_flat;
  logic [CNT_W-1:0]      cnt_arr [2];
  logic [BW-1:0]         bits_arr [2];
  logic                  run, tick;
  logic                  clr_shadow, sample, commit, wipe;
  logic [IW-1:0]         sample_idx;
  logic [BW-1:0]         ob, ib, tb;

  assign cnt_arr[0] = out_count;
  assign cnt_arr[1] = in_count;

  sgc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  genvar d;
  generate
    for (d = 0; d < 2; d++) begin : g_dir
      sgc_count_decode #(.CNT_W(CNT_W), .PORTS(PORTS)) u_dec (
        .pin_count (cnt_arr[d]),
        .bit_count (bits_arr[d])
      );
    end
  endgenerate

  sgc_host_regs #(.PORTS(PORTS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .out_flat (out_flat),
    .in_flat  (in_flat),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  sgc_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (run),
    .tick  (tick)
  );

  sgc_scan_seq #(.PORTS(PORTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .ob_in      (bits_arr[0]),
    .ib_in      (bits_arr[1]),
    .out_flat   (out_flat),
    .tick       (tick),
    .run        (run),
    .sclk       (sclk),
    .sdout      (sdout),
    .in_load    (in_load),
    .out_latch  (out_latch),
    .clr_shadow (clr_shadow),
    .sample     (sample),
    .sample_idx (sample_idx),
    .commit     (commit),
    .wipe       (wipe),
    .ob         (ob),
    .ib         (ib),
    .tb         (tb)
  );

  sgc_in_capture #(.PORTS(PORTS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .sdin       (sdin),
    .clr_shadow (clr_shadow),
    .sample     (sample),
    .sample_idx (sample_idx),
    .commit     (commit),
    .wipe       (wipe),
    .in_flat    (in_flat)
  );
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
  parameter int PINS = 64,
  parameter int BW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            sdout,
  input logic            in_load,
  input logic            out_latch,
  input logic            commit,
  input logic            wipe,
  input logic [PINS-1:0] in_flat,
  input logic [BW-1:0]   ob,
  input logic [BW-1:0]   ib,
  input logic [BW-1:0]   tb
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sclk && !sdout && !in_load && !out_latch && in_flat == '0);
    end
  end

  assert_strobe_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load || out_latch) |-> !sclk);

  assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_load && out_latch));

  assert_data_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdout));

  assert_no_load_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |-> (ib != '0));

  assert_no_latch_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_latch |-> (ob != '0));

  assert_no_shift_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (tb != '0));

  assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(commit) && !$past(wipe)) |-> $stable(in_flat));
endmodule

bind sgc_chain_top sgc_checker #(.PINS(PINS), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .sdout     (sdout),
  .in_load   (in_load),
  .out_latch (out_latch),
  .commit    (commit),
  .wipe      (wipe),
  .in_flat   (in_flat),
  .ob        (ob),
  .ib        (ib),
  .tb        (tb)
);

// File: tb/tb_sgc_chain_top.sv
module tb_sgc_chain_top;
  localparam int CLK_P  = 10;
  localparam int HALF   = 2;
  localparam int SCAN   = 1 + 2 * HALF + 128 * HALF;
  localparam int SETTLE = 3 * SCAN + 20;

  logic       clk, rst_n, wr_en, sclk, sdout, out_latch, sdin, in_load;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [6:0] out_count, in_count;

  sgc_chain_top #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_count(out_count), .in_count(in_count),
    .sclk(sclk), .sdout(sdout), .out_latch(out_latch), .sdin(sdin), .in_load(in_load)
  );

  int nchk = 0;
  int nfail = 0;
  int rises = 0, loads = 0, latches = 0;
  int ilen = 0;
  logic [63:0] ich = '0, ipat = '0, och = '0, opins = '0;

  // external chain models
  always @(posedge sclk) begin
    rises++;
    ich <= ich << 1;
    och <= {och[62:0], sdout};
  end
  always @(posedge in_load) begin
    loads++;
    ich <= ipat;
  end
  always @(posedge out_latch) begin
    latches++;
    opins <= och;
  end
  always_comb sdin = (ilen == 0) ? 1'b0 : ich[ilen-1];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  localparam int NV = 8;
  localparam logic [141:0] VEC [NV] = '{
    {7'd64,  7'd64, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
    {7'd9,   7'd20, 64'hFFFFFFFFFFFFA55A, 64'hFFFFFFFFFFC33C5A},
    {7'd8,   7'd0,  64'h00000000000000B7, 64'hFFFFFFFFFFFFFFFF},
    {7'd0,   7'd16, 64'h1111111111111111, 64'h000000000000E10F},
    {7'd100, 7'd70, 64'h8000000000000001, 64'h7FFFFFFFFFFFFFFE},
    {7'd1,   7'd1,  64'hFFFFFFFFFFFFFF81, 64'hFFFFFFFFFFFFFF3C},
    {7'd33,  7'd57, 64'hAAAA_5555_CAFE_F00D, 64'h9696_6969_0F0F_F0F0},
    {7'd64,  7'd8,  64'hDEADBEEF01020304, 64'h00000000000000A5}
  };

  function automatic int bports(input int c);
    int s;
    s = (c > 64) ? 64 : c;
    return (s + 7) / 8;
  endfunction

  function automatic logic [63:0] lowmask(input int nbits);
    return (nbits >= 64) ? '1 : ((64'd1 << nbits) - 64'd1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_counts(input int o, input int i);
    @(negedge clk);
    out_count = 7'(o);
    in_count  = 7'(i);
    ilen      = 8 * bports(i);
  endtask

  task automatic write_out(input logic [63:0] pat);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = pat[a*8 +: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_in(output logic [63:0] v);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      rd_addr = 3'(a);
      #1 v[a*8 +: 8] = rd_data;
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] rv, mk;
    int no, ni, r0;
    time t0;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    out_count = 7'd64; in_count = 7'd64; ilen = 64;
    #1 rst_n = 1'b0;
    wait_cycles(3);
    // R1 reset state
    check("R1 strobes", {60'd0, sclk, sdout, in_load, out_latch}, 64'd0);
    read_in(rv);
    check("R1 inregs", rv, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // vector table walk: R2 R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      no = int'(VEC[v][141:135]);
      ni = int'(VEC[v][134:128]);
      set_counts(no, ni);
      write_out(VEC[v][127:64]);
      ipat = VEC[v][63:0];
      wait_cycles(SETTLE);
      if (no > 0) begin
        mk = lowmask(8 * bports(no));
        check("R2 R4 R10 outpins", opins & mk, VEC[v][127:64] & mk);
      end
      read_in(rv);
      check("R5 R10 inregs", rv, ipat & lowmask(8 * bports(ni)));
      if (no > 0) begin
        @(posedge out_latch);
        r0 = rises;
        @(posedge out_latch);
        check("R3 shift edges", 64'(rises - r0),
              64'(8 * ((bports(no) > bports(ni)) ? bports(no) : bports(ni))));
      end
    end

    // R11 phase widths
    @(posedge sclk); t0 = $time;
    @(negedge sclk);
    check("R11 high phase", 64'($time - t0), 64'(HALF * CLK_P));
    t0 = $time;
    @(posedge sclk);
    check("R11 low phase", 64'($time - t0), 64'(HALF * CLK_P));

    // R6 stale read during shifting
    set_counts(64, 64);
    ipat = 64'h1234_5678_9ABC_DEF0;
    wait_cycles(SETTLE);
    ipat = 64'h0F1E_2D3C_4B5A_6978;
    @(posedge in_load);
    wait_cycles(20);
    read_in(rv);
    check("R6 mid-scan", rv, 64'h1234_5678_9ABC_DEF0);
    wait_cycles(SETTLE);
    read_in(rv);
    check("R6 after scan", rv, 64'h0F1E_2D3C_4B5A_6978);

    // R9 zero output count: no latch
    set_counts(0, 16);
    wait_cycles(SCAN + 10);
    r0 = latches;
    wait_cycles(SETTLE);
    check("R9 no latch", 64'(latches - r0), 64'd0);
    // R9 zero input count: no load
    set_counts(8, 0);
    wait_cycles(SCAN + 10);
    r0 = loads;
    wait_cycles(SETTLE);
    check("R9 no load", 64'(loads - r0), 64'd0);
    // R9 both zero: no shifting, inputs cleared
    set_counts(16, 16);
    ipat = '1;
    wait_cycles(SETTLE);
    set_counts(0, 0);
    wait_cycles(SCAN + 10);
    r0 = rises;
    wait_cycles(SETTLE);
    check("R9 no sclk", 64'(rises - r0), 64'd0);
    read_in(rv);
    check("R9 inregs zero", rv, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule